// File: doc/BRIEF.md
# Serial Flash Erase and Buffer-Load Command Decoder

This block is the device-side command front end of a page-organised serial flash. The select, serial clock and data lines arrive from the pins with no timing relation to the system clock. They are synchronised into the system clock domain, and their edges are detected there. While the device is selected, each rising serial-clock edge shifts one bit into a 32-bit command frame, most significant bit first. The first eight bits are the opcode and the next 24 bits are the address field.

A complete frame with a known opcode is not acted on when its last bit arrives. It is held until the host deselects the device. On that rising edge of the select line, the block issues a one-cycle start strobe together with an operation code, a page number, a block number and a buffer selector. These go to the array controller. A self-timed busy phase follows, and its length depends on the operation. During that phase the ready status bit reads 0. The host polls this bit to learn when the array has finished. Erase operations set the target cells to all ones; that work belongs to the array controller and is outside this block.

Top module: `flash_cmd_decoder`

## Requirements
- R1: While reset is held and in the first cycle after it is released, `status_rdy` is 1, `op_start` is 0 and `op_code` is 0.
- R2: The frame is shifted on rising `sck` edges while `cs_n` is low, MSB first. Bits 31..24 are the opcode, bits 23..20 are reserved, bits 19..9 are the 11-bit page and bits 8..0 are don't-care. The reserved bits and the don't-care bits have no effect on any output.
- R3: Opcode 0x81 (page erase) gives `op_code`=1 and `op_page` = the page field. `op_block` always equals `op_page[10:3]`.
- R4: Opcode 0x53 gives `op_code`=3 with `op_buf`=0, and opcode 0x55 gives `op_code`=3 with `op_buf`=1. In both cases `op_page` = the page field.
- R5: Opcode 0x50 (block erase) gives `op_code`=2. `op_block` = frame bits 19..12, and `op_page` = `op_block`*8, the first of the block's eight pages.
- R6: An operation is launched only after `cs_n` rises. `op_start` is a single-cycle pulse, and the operation outputs keep their values until the next launch.
- R7: If `cs_n` rises after fewer than 32 bits have been shifted, the frame is dropped and no operation starts.
- R8: A complete frame with any other opcode starts nothing and leaves `status_rdy` at 1.
- R9: `status_rdy` falls in the cycle that `op_start` is high. It stays 0 for exactly PAGE_ERASE_CYCLES, BLOCK_ERASE_CYCLES or XFER_CYCLES cycles, according to the operation, and then returns to 1.
- R10: A frame whose `cs_n` rise is seen while `status_rdy` is 0 is dropped. The busy phase already running keeps its length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sck | input | 1 | Serial clock from the host, asynchronous |
| cs_n | input | 1 | Active-low device select, asynchronous |
| mosi | input | 1 | Serial command data, asynchronous |
| op_start | output | 1 | One-cycle strobe when an operation is launched |
| op_code | output | 2 | Launched operation: 0 none, 1 page erase, 2 block erase, 3 page-to-buffer |
| op_page | output | 11 | Target page (first page of the block for a block erase) |
| op_block | output | 8 | Block holding the target page |
| op_buf | output | 1 | Destination buffer of a transfer: 0 first, 1 second |
| status_rdy | output | 1 | Ready status bit: 0 while a self-timed operation runs |

## Verification
The in-line assertions check, on every cycle, that a start is a single pulse and only follows a ready cycle. They also check that a start always carries a valid code, that the busy phase begins with the start, and that a block erase names an aligned page. They check that the operation outputs never move between launches and that the bit counter never passes the frame length. Only the bench's scenarios can show that the fields come from the correct frame bit positions, that the busy length matches the operation, and that frames are dropped correctly. The dropped cases are short frames, unknown opcodes and frames that arrive while busy. The bench also shows that nothing launches while the select line is still low.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

    localparam int FRAME_BITS = 32;
    localparam int OPC_W      = 8;
    localparam int PAGE_W     = 11;
    localparam int BLOCK_W    = 8;
    localparam int PAGE_LSB   = 9;
    localparam int CNT_W      = $clog2(FRAME_BITS + 1);

    localparam logic [OPC_W-1:0] OPC_PAGE_ERASE  = 8'h81;
    localparam logic [OPC_W-1:0] OPC_BLOCK_ERASE = 8'h50;
    localparam logic [OPC_W-1:0] OPC_LOAD_BUF0   = 8'h53;
    localparam logic [OPC_W-1:0] OPC_LOAD_BUF1   = 8'h55;

    typedef enum logic [1:0] {
        OP_NONE        = 2'd0,
        OP_PAGE_ERASE  = 2'd1,
        OP_BLOCK_ERASE = 2'd2,
        OP_LOAD_BUF    = 2'd3
    } op_e;

    typedef struct packed {
        op_e               code;
        logic [PAGE_W-1:0] page;
        logic              buf_sel;
    } cmd_t;

    function automatic cmd_t decode_cmd(input logic [OPC_W-1:0] opc,
                                        input logic [PAGE_W-1:0] pg);
        cmd_t c;
        c.code    = OP_NONE;
        c.page    = pg;
        c.buf_sel = 1'b0;
        case (opc)
            OPC_PAGE_ERASE:  c.code = OP_PAGE_ERASE;
            OPC_BLOCK_ERASE: begin
                c.code = OP_BLOCK_ERASE;
                c.page = {pg[PAGE_W-1:PAGE_W-BLOCK_W], {(PAGE_W-BLOCK_W){1'b0}}};
            end
            OPC_LOAD_BUF0:   c.code = OP_LOAD_BUF;
            OPC_LOAD_BUF1:   begin
                c.code    = OP_LOAD_BUF;
                c.buf_sel = 1'b1;
            end
            default:         c.code = OP_NONE;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/flash_sync_edge.sv
module flash_sync_edge #(
    parameter int WIDTH  = 3,
    parameter int STAGES = 2,
    parameter logic [WIDTH-1:0] IDLE = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] lvl,
    output logic [WIDTH-1:0] rise
);
    generate
        for (genvar b = 0; b < WIDTH; b++) begin : g_bit
            logic [STAGES-1:0] chain;
            logic              prev;
            always_ff @(posedge clk) begin
                if (rst) begin
                    chain <= {STAGES{IDLE[b]}};
                    prev  <= IDLE[b];
                end else begin
                    chain <= {chain[STAGES-2:0], din[b]};
                    prev  <= chain[STAGES-1];
                end
            end
            assign lvl[b]  = chain[STAGES-1];
            assign rise[b] = chain[STAGES-1] & ~prev;
        end
    endgenerate
endmodule

// File: rtl/flash_cmd_shifter.sv
module flash_cmd_shifter
    import flash_cmd_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              desel,
    input  logic              sck_rise,
    input  logic              data_bit,
    output logic [OPC_W-1:0]  opcode,
    output logic [PAGE_W-1:0] page,
    output logic              full
);
    logic [FRAME_BITS-1:0] sr;
    logic [CNT_W-1:0]      cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            sr  <= '0;
            cnt <= '0;
        end else if (desel) begin
            cnt <= '0;
        end else if (sck_rise && (cnt < CNT_W'(FRAME_BITS))) begin
            sr  <= {sr[FRAME_BITS-2:0], data_bit};
            cnt <= cnt + 1'b1;
        end
    end

    assign opcode = sr[FRAME_BITS-1 -: OPC_W];
    assign page   = sr[PAGE_LSB +: PAGE_W];
    assign full   = (cnt == CNT_W'(FRAME_BITS));

    AST_BITCNT_BOUND: assert property (@(posedge clk) disable iff (rst)
        cnt <= CNT_W'(FRAME_BITS)) else $error("bit count overran"); // R7
    AST_DESEL_CLEARS: assert property (@(posedge clk) disable iff (rst)
        desel |=> (cnt == '0)) else $error("count kept after deselect"); // R7
endmodule

// File: rtl/flash_busy_timer.sv
module flash_busy_timer
    import flash_cmd_pkg::*;
#(
    parameter int PAGE_ERASE_CYCLES  = 20,
    parameter int BLOCK_ERASE_CYCLES = 400,
    parameter int XFER_CYCLES        = 12
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  op_e  code,
    output logic busy
);
    localparam int MAX_AB = (PAGE_ERASE_CYCLES > BLOCK_ERASE_CYCLES) ?
                            PAGE_ERASE_CYCLES : BLOCK_ERASE_CYCLES;
    localparam int MAXC   = (MAX_AB > XFER_CYCLES) ? MAX_AB : XFER_CYCLES;
    localparam int CW     = $clog2(MAXC + 1);

    logic [CW-1:0] cnt;
    logic [CW-1:0] load;

    always_comb begin
        case (code)
            OP_BLOCK_ERASE: load = CW'(BLOCK_ERASE_CYCLES - 1);
            OP_LOAD_BUF:    load = CW'(XFER_CYCLES - 1);
            default:        load = CW'(PAGE_ERASE_CYCLES - 1);
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            busy <= 1'b0;
            cnt  <= '0;
        end else if (start && !busy) begin
            busy <= 1'b1;
            cnt  <= load;
        end else if (busy) begin
            if (cnt == '0) busy <= 1'b0;
            else           cnt  <= cnt - 1'b1;
        end
    end

    AST_BUSY_CNT_RANGE: assert property (@(posedge clk) disable iff (rst)
        busy |-> (cnt < CW'(MAXC))) else $error("busy count out of range"); // R9
    AST_START_SETS_BUSY: assert property (@(posedge clk) disable iff (rst)
        (start && !busy) |=> busy) else $error("start did not raise busy"); // R9
endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
    import flash_cmd_pkg::*;
#(
    parameter int SYNC_STAGES        = 2,
    parameter int PAGE_ERASE_CYCLES  = 20,
    parameter int BLOCK_ERASE_CYCLES = 400,
    parameter int XFER_CYCLES        = 12
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        sck,
    input  logic        cs_n,
    input  logic        mosi,
    output logic        op_start,
    output logic [1:0]  op_code,
    output logic [10:0] op_page,
    output logic [7:0]  op_block,
    output logic        op_buf,
    output logic        status_rdy
);
    localparam int PIN_W = 3;

    logic [PIN_W-1:0] pin_lvl, pin_rise;
    logic [OPC_W-1:0] opcode;
    logic [PAGE_W-1:0] page_fld;
    logic             frame_full;
    logic             busy;
    logic             launch;
    cmd_t             cmd;
    cmd_t             cur_q;

    flash_sync_edge #(.WIDTH(PIN_W), .STAGES(SYNC_STAGES), .IDLE(3'b010)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .din  ({mosi, cs_n, sck}),
        .lvl  (pin_lvl),
        .rise (pin_rise)
    );

    flash_cmd_shifter u_shift (
        .clk      (clk),
        .rst      (rst),
        .desel    (pin_lvl[1]),
        .sck_rise (pin_rise[0]),
        .data_bit (pin_lvl[2]),
        .opcode   (opcode),
        .page     (page_fld),
        .full     (frame_full)
    );

    assign cmd    = decode_cmd(opcode, page_fld);
    assign launch = pin_rise[1] && frame_full && (cmd.code != OP_NONE) && !busy;

    flash_busy_timer #(
        .PAGE_ERASE_CYCLES  (PAGE_ERASE_CYCLES),
        .BLOCK_ERASE_CYCLES (BLOCK_ERASE_CYCLES),
        .XFER_CYCLES        (XFER_CYCLES)
    ) u_timer (
        .clk   (clk),
        .rst   (rst),
        .start (launch),
        .code  (cmd.code),
        .busy  (busy)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            op_start <= 1'b0;
            cur_q    <= '{code: OP_NONE, page: '0, buf_sel: 1'b0};
        end else begin
            op_start <= launch;
            if (launch) cur_q <= cmd;
        end
    end

    assign op_code    = cur_q.code;
    assign op_page    = cur_q.page;
    assign op_block   = cur_q.page[PAGE_W-1 -: BLOCK_W];
    assign op_buf     = cur_q.buf_sel;
    assign status_rdy = ~busy;

    AST_START_PULSE: assert property (@(posedge clk) disable iff (rst)
        op_start |=> !op_start) else $error("start longer than one cycle"); // R6
    AST_FIELDS_HOLD: assert property (@(posedge clk) disable iff (rst)
        !op_start |-> ($stable(op_page) && $stable(op_code) && $stable(op_buf)))
        else $error("operation outputs moved without a start"); // R6
    AST_START_VALID_CODE: assert property (@(posedge clk) disable iff (rst)
        op_start |-> (op_code != 2'd0)) else $error("start with no operation"); // R8
    AST_BUSY_WITH_START: assert property (@(posedge clk) disable iff (rst)
        op_start |-> !status_rdy) else $error("busy not raised with start"); // R9
    AST_START_FROM_READY: assert property (@(posedge clk) disable iff (rst)
        op_start |-> $past(status_rdy)) else $error("start while busy"); // R10
    AST_BLOCK_ALIGNED: assert property (@(posedge clk) disable iff (rst)
        (op_start && op_code == 2'd2) |-> (op_page[2:0] == 3'd0))
        else $error("block erase page not aligned"); // R5
endmodule

// File: tb/sim_flash_cmd_decoder.sv
module sim_flash_cmd_decoder;
    localparam int PE = 20;
    localparam int BE = 400;
    localparam int XF = 12;
    localparam int WATCHDOG = 190000;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic sck = 1'b0;
    logic cs_n = 1'b1;
    logic mosi = 1'b0;
    logic        op_start;
    logic [1:0]  op_code;
    logic [10:0] op_page;
    logic [7:0]  op_block;
    logic        op_buf;
    logic        status_rdy;

    int checks = 0;
    int errors = 0;
    int starts = 0;
    int busy_run = 0;
    int last_busy = 0;
    int cyc = 0;
    int cap_code, cap_page, cap_block, cap_buf;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    flash_cmd_decoder #(
        .SYNC_STAGES(2), .PAGE_ERASE_CYCLES(PE),
        .BLOCK_ERASE_CYCLES(BE), .XFER_CYCLES(XF)
    ) u0 (
        .clk(clk), .rst(rst), .sck(sck), .cs_n(cs_n), .mosi(mosi),
        .op_start(op_start), .op_code(op_code), .op_page(op_page),
        .op_block(op_block), .op_buf(op_buf), .status_rdy(status_rdy)
    );

    always @(negedge clk) begin
        if (!rst) begin
            if (op_start) begin
                starts++;
                cap_code  = op_code;
                cap_page  = op_page;
                cap_block = op_block;
                cap_buf   = op_buf;
            end
            if (!status_rdy) busy_run++;
            else if (busy_run != 0) begin
                last_busy = busy_run;
                busy_run  = 0;
            end
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic send(input logic [7:0] opc, input logic [23:0] addr,
                        input int nbits, input int hold);
        logic [31:0] fr;
        fr = {opc, addr};
        @(negedge clk);
        cs_n = 1'b0;
        repeat (4) @(negedge clk);
        for (int i = 0; i < nbits; i++) begin
            mosi = fr[31-i];
            repeat (4) @(negedge clk);
            sck = 1'b1;
            repeat (4) @(negedge clk);
            sck = 1'b0;
        end
        repeat (4 + hold) @(negedge clk);
        cs_n = 1'b1;
    endtask

    task automatic expect_op(input logic [7:0] opc, input logic [23:0] addr,
                             input int code, input int page, input int bsel,
                             input int blen, input string tag);
        int s0;
        s0 = starts;
        last_busy = 0;
        send(opc, addr, 32, 0);
        repeat (20) @(negedge clk);
        chk(starts == s0 + 1, {tag, " start count"}, starts - s0, 1);
        chk(cap_code == code, {tag, " op_code"}, cap_code, code);
        chk(cap_page == page, {tag, " op_page"}, cap_page, page);
        chk(cap_block == (page >> 3), {tag, " R3 op_block"}, cap_block, page >> 3);
        chk(cap_buf == bsel, {tag, " op_buf"}, cap_buf, bsel);
        for (int i = 0; i < blen + 50 && !status_rdy; i++) @(negedge clk);
        repeat (3) @(negedge clk);
        chk(last_busy == blen, {tag, " R9 busy length"}, last_busy, blen);
    endtask

    task automatic expect_none(input logic [7:0] opc, input logic [23:0] addr,
                               input int nbits, input string tag);
        int s0;
        s0 = starts;
        send(opc, addr, nbits, 0);
        repeat (30) @(negedge clk);
        chk(starts == s0, {tag, " no start"}, starts - s0, 0);
        chk(status_rdy == 1'b1, {tag, " stays ready"}, status_rdy, 1);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > WATCHDOG && !finished) begin
            finished = 1'b1;
            errors++;
            checks++;
            $display("FAIL watchdog (all requirements): actual=%0d expected<%0d", cyc, WATCHDOG);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        // R1: reset state, during reset and right after release
        chk(status_rdy == 1'b1, "R1 ready in reset", status_rdy, 1);
        chk(op_start == 1'b0, "R1 start in reset", op_start, 0);
        rst = 1'b0;
        @(negedge clk);
        chk(status_rdy == 1'b1, "R1 ready after reset", status_rdy, 1);
        chk(op_start == 1'b0, "R1 start after reset", op_start, 0);
        chk(op_code == 2'd0, "R1 code after reset", op_code, 0);

        // R3, R4, R2: page sweep; reserved and don't-care bits vary
        for (int p = 0; p < 2048; p += 37) begin
            logic [3:0] rsv;
            logic [8:0] dc;
            rsv = 4'(p);
            dc  = 9'(p * 7);
            expect_op(8'h81, {rsv, 11'(p), dc}, 1, p, 0, PE, "R3 R2 page erase");
            expect_op((p % 2 == 1) ? 8'h55 : 8'h53, {~rsv, 11'(p), ~dc},
                      3, p, p % 2, XF, "R4 R2 transfer");
        end
        expect_op(8'h81, {4'hF, 11'h7FF, 9'h1FF}, 1, 2047, 0, PE, "R3 top page");
        expect_op(8'h55, {4'h0, 11'h000, 9'h000}, 3, 0, 1, XF, "R4 page zero buf1");

        // R5: block sweep
        for (int b = 0; b < 256; b += 5) begin
            expect_op(8'h50, {4'(b), 8'(b), 12'(b * 3)}, 2, b * 8, 0, BE, "R5 block erase");
        end
        expect_op(8'h50, {4'hA, 8'hFF, 12'hFFF}, 2, 255 * 8, 0, BE, "R5 last block");

        // R7: short frames
        expect_none(8'h81, 24'h012345, 31, "R7 31 bits");
        expect_none(8'h81, 24'h012345, 8, "R7 opcode only");
        expect_none(8'h53, 24'h000000, 0, "R7 empty select");

        // R8: unknown opcodes
        expect_none(8'hA5, 24'h0ABCDE, 32, "R8 opcode A5");
        expect_none(8'h80, 24'h000200, 32, "R8 opcode 80");
        expect_none(8'h54, 24'h000200, 32, "R8 opcode 54");

        // R6: no launch while select is still low
        begin
            int s0;
            s0 = starts;
            fork
                send(8'h81, {4'h0, 11'd100, 9'h0}, 32, 60);
                begin
                    repeat (4 + 32 * 8 + 50) @(negedge clk);
                    chk(starts == s0, "R6 no start before select rises", starts - s0, 0);
                end
            join
            repeat (20) @(negedge clk);
            chk(starts == s0 + 1, "R6 start after select rises", starts - s0, 1);
            chk(cap_page == 100, "R6 page", cap_page, 100);
            repeat (PE + 10) @(negedge clk);
        end

        // R10: frame during busy is dropped, busy length kept
        begin
            int s0;
            s0 = starts;
            last_busy = 0;
            send(8'h50, {4'h0, 8'd7, 12'h0}, 32, 0);
            repeat (10) @(negedge clk);
            send(8'h81, {4'h0, 11'd5, 9'h0}, 32, 0);
            repeat (20) @(negedge clk);
            chk(starts == s0 + 1, "R10 second frame dropped", starts - s0, 1);
            chk(cap_code == 2, "R10 running op kept", cap_code, 2);
            for (int i = 0; i < BE + 50 && !status_rdy; i++) @(negedge clk);
            repeat (3) @(negedge clk);
            chk(last_busy == BE, "R10 busy length kept", last_busy, BE);
            chk(cap_page == 56, "R10 outputs hold", op_page, 56);
        end

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule